// File: doc/BRIEF.md
# Configurable Read/Write Port Memory

A single-clock storage array with one write port and one read port. The shape of the array (word count, word width, write chunk size) and the behaviour of the read port are fixed by parameters at elaboration. The read port is either registered, with data one edge after the address, or combinational. When it is registered it is either transparent, so that a read that collides with a write to the same word returns the new contents, or old-data, so that the collision returns what was stored before the edge.

Writes are split into equal chunks of `GRAN` bits, each with its own enable bit, so a caller can update single bytes or fields of a word. `GRAN` defaults to the word width, which leaves one enable bit. The array can be preloaded from the `INIT` parameter. Configurations that cannot be built are refused at elaboration: a chunk size that is zero, wider than the word or not an exact divisor of it, and a combinational read port that is not transparent.

Top module: `rw_mem`

## Requirements
- R1: With `SYNC_RD=1`, `rd_data` shows the word at the `rd_addr` sampled on a rising edge from just after that edge on, and not before.
- R2: With `SYNC_RD=0`, `rd_data` equals the stored word at the current `rd_addr` at all times, and it shows a write from the rising edge that performs it.
- R3: With `SYNC_RD=1, TRANSP=1`, a read of the word being written on the same edge returns, per chunk, the new data where the chunk enable is 1 and the old stored data where it is 0.
- R4: With `SYNC_RD=1, TRANSP=0`, a read of the word being written on the same edge returns the whole word as stored before that edge.
- R5: With `TRANSP=0`, the read register loads only on edges where `rd_en` is 1 and otherwise keeps its value; with `TRANSP=1`, `rd_en` has no effect and the register loads on every edge.
- R6: A write presented before a rising edge is stored on that edge and is returned by any read whose address is sampled on a later edge.
- R7: `wr_en` bit k writes data bits `[k*GRAN +: GRAN]` only; stored bits of chunks whose enable bit is 0 are left unchanged, and with all bits 0 nothing is stored.
- R8: While `rst_n` is 0 the read register is 0; the array is not cleared by reset and holds word i of `INIT` (bits `[i*WIDTH +: WIDTH]`) until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| wr_addr | input | AW | Write word address, AW = clog2(DEPTH) |
| wr_data | input | WIDTH | Write data |
| wr_en | input | WIDTH/GRAN | One enable per write chunk |
| rd_addr | input | AW | Read word address |
| rd_en | input | 1 | Read register load enable, used only when not transparent |
| rd_data | output | WIDTH | Read data |

## Verification
A write is due in storage on the first rising edge after it is driven; a registered read is due on `rd_data` just after the edge that samples its address, and a combinational read is due as soon as the address settles. The bench drives every input on the falling edge, checks the combinational instance one nanosecond later against the model array as it stood before the coming edge, then advances its model across the rising edge and checks both registered instances at the following falling edge. Addresses are drawn from a small range so that same-word collisions under random chunk enables and random `rd_en` happen often in all three read-port variants.

// File: rtl/rw_mem.sv
module rw_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int GRAN = WIDTH,
  parameter bit TRANSP = 1'b1,
  parameter bit SYNC_RD = 1'b1,
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
  localparam int CHUNKS = WIDTH / GRAN,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [CHUNKS-1:0] wr_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data
);

  if (GRAN < 1 || GRAN > WIDTH || (WIDTH % GRAN) != 0) begin : g_bad_gran
    $error("rw_mem: GRAN must divide WIDTH exactly");
  end
  if (!SYNC_RD && !TRANSP) begin : g_bad_mode
    $error("rw_mem: a combinational read port must be transparent");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] wmask, stored, next_rd, rd_q;
  logic             hit, rd_fire;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*WIDTH +: WIDTH];
  end

  for (genvar k = 0; k < CHUNKS; k++) begin : g_mask
    assign wmask[k*GRAN +: GRAN] = {GRAN{wr_en[k]}};
  end

  assign stored  = mem[rd_addr];
  assign hit     = (wr_addr == rd_addr) && (|wr_en);
  assign next_rd = (TRANSP && hit) ? ((stored & ~wmask) | (wr_data & wmask)) : stored;
  assign rd_fire = TRANSP ? 1'b1 : rd_en;

  always_ff @(posedge clk) begin
    if (|wr_en) mem[wr_addr] <= (mem[wr_addr] & ~wmask) | (wr_data & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= next_rd;
  end

  assign rd_data = SYNC_RD ? rd_q : stored;

endmodule

module rw_mem_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int CHUNKS = 1,
  parameter bit TRANSP = 1'b1,
  parameter bit SYNC_RD = 1'b1,
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [CHUNKS-1:0] wr_en,
  input logic [AW-1:0]     rd_addr,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data
);
  logic [1:0] age;
  logic       warm, full, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age >= 2'd2);
  assign full = &wr_en;
  assign fire = TRANSP ? 1'b1 : rd_en;

  if (SYNC_RD && TRANSP) begin : g_tr
    a_r3_bypass_new: assert property (@(posedge clk) disable iff (!rst_n)
      full && (wr_addr == rd_addr) |=> rd_data == $past(wr_data));
  end
  if (SYNC_RD && !TRANSP) begin : g_nt
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      warm && !rd_en |=> $stable(rd_data));
  end
  if (SYNC_RD) begin : g_sy
    a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      warm && $past(full) && fire && (rd_addr == $past(wr_addr)) &&
      !((|wr_en) && (wr_addr == rd_addr))
      |=> rd_data == $past(wr_data, 2));
  end else begin : g_as
    a_r2_async_sees_write: assert property (@(posedge clk) disable iff (!rst_n)
      warm && $past(full) && (rd_addr == $past(wr_addr)) |-> rd_data == $past(wr_data));
  end
endmodule

bind rw_mem rw_mem_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .CHUNKS(CHUNKS),
  .TRANSP(TRANSP), .SYNC_RD(SYNC_RD), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_en(wr_en), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/rw_mem_tb_top.sv
`timescale 1ns/1ps
module rw_mem_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int GRAN = 8;
  localparam int CH = WIDTH / GRAN;
  localparam int AW = 4;

  function automatic logic [DEPTH*WIDTH-1:0] mk_init();
    logic [DEPTH*WIDTH-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*WIDTH +: WIDTH] = 32'hA500_0000 ^ (i * 32'h0001_0203);
    return v;
  endfunction
  localparam logic [DEPTH*WIDTH-1:0] INIT_V = mk_init();

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [WIDTH-1:0] wd = '0;
  logic [CH-1:0] we = '0;
  logic re = 1'b0;
  logic [WIDTH-1:0] q_t, q_n, q_a;

  always #10 clk = ~clk;

  rw_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GRAN(GRAN), .TRANSP(1'b1), .SYNC_RD(1'b1), .INIT(INIT_V))
    dut_i (.clk(clk), .rst_n(rst_n), .wr_addr(wa), .wr_data(wd), .wr_en(we),
           .rd_addr(ra), .rd_en(re), .rd_data(q_t));
  rw_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GRAN(GRAN), .TRANSP(1'b0), .SYNC_RD(1'b1), .INIT(INIT_V))
    dut_nt (.clk(clk), .rst_n(rst_n), .wr_addr(wa), .wr_data(wd), .wr_en(we),
            .rd_addr(ra), .rd_en(re), .rd_data(q_n));
  rw_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GRAN(GRAN), .TRANSP(1'b1), .SYNC_RD(1'b0), .INIT(INIT_V))
    dut_as (.clk(clk), .rst_n(rst_n), .wr_addr(wa), .wr_data(wd), .wr_en(we),
            .rd_addr(ra), .rd_en(re), .rd_data(q_a));

  int total = 0, bad = 0;
  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] exp_t, exp_n;

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old, input logic [WIDTH-1:0] nw,
                                             input logic [CH-1:0] en);
    logic [WIDTH-1:0] r = old;
    for (int k = 0; k < CH; k++) if (en[k]) r[k*GRAN +: GRAN] = nw[k*GRAN +: GRAN];
    return r;
  endfunction

  // one cycle: drive at falling edge, check comb port, advance model, check registered ports
  task automatic step(input logic [AW-1:0] a_w, input logic [WIDTH-1:0] d, input logic [CH-1:0] e,
                      input logic [AW-1:0] a_r, input logic r_en);
    logic [WIDTH-1:0] cur;
    wa = a_w; wd = d; we = e; ra = a_r; re = r_en;
    #1;
    chk("R2 comb read of stored word", q_a, model[a_r]);
    cur = model[a_r];
    exp_t = (e != '0 && a_w == a_r) ? merge(cur, d, e) : cur;   // R3, R5 transparent ignores rd_en
    if (r_en) exp_n = cur;                                         // R4 old data, R5 hold
    if (e != '0) model[a_w] = merge(model[a_w], d, e);             // R6, R7
    @(posedge clk);
    @(negedge clk);
    chk("R1 R3 transparent registered read", q_t, exp_t);
    chk("R1 R4 R5 old-data registered read", q_n, exp_n);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = INIT_V[i*WIDTH +: WIDTH];
    exp_t = '0; exp_n = '0;
    repeat (3) @(negedge clk);
    // R8: read register cleared, array kept at INIT
    chk("R8 reset transparent", q_t, '0);
    chk("R8 reset old-data", q_n, '0);
    #1 chk("R8 init content on comb port", q_a, INIT_V[0 +: WIDTH]);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R8: read preloaded words
    for (int i = 0; i < 6; i++) step('0, '0, '0, AW'(i), 1'b1);
    // R3 R4: full-word collision
    step(4'd2, 32'h1111_2222, 4'hF, 4'd2, 1'b1);
    // R6: written word visible next read
    step(4'd0, '0, '0, 4'd2, 1'b1);
    chk("R6 new word stored", q_n, 32'h1111_2222);
    // R3 R7: partial collision merges chunks
    step(4'd3, 32'hDEAD_BEEF, 4'b0101, 4'd3, 1'b1);
    step(4'd0, '0, '0, 4'd3, 1'b1);
    chk("R7 partial write merge", q_t, merge(INIT_V[3*WIDTH +: WIDTH], 32'hDEAD_BEEF, 4'b0101));
    // R7: zero enables store nothing
    step(4'd4, 32'hFFFF_FFFF, '0, 4'd5, 1'b1);
    step(4'd0, '0, '0, 4'd4, 1'b1);
    chk("R7 no enable no change", q_t, INIT_V[4*WIDTH +: WIDTH]);
    // R5: hold with rd_en low while address and contents change
    step(4'd6, 32'h0BAD_F00D, 4'hF, 4'd6, 1'b0);
    step(4'd7, 32'h1234_5678, 4'hF, 4'd7, 1'b0);
    chk("R5 old-data port holds", q_n, INIT_V[4*WIDTH +: WIDTH]);
    // random traffic in a narrow address window
    for (int n = 0; n < 400; n++)
      step(AW'($urandom_range(0, 3)), $urandom, CH'($urandom), AW'($urandom_range(0, 3)),
           1'($urandom));
    // R8: reset mid-run clears register, not array
    rst_n = 1'b0;
    #1;
    chk("R8 reset again transparent", q_t, '0);
    chk("R8 reset again old-data", q_n, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_n = '0;
    for (int i = 0; i < 4; i++) step('0, '0, '0, AW'(i), 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule